// File: doc/BRIEF.md
# Model-Select Job Gate

The gate sits in front of a compute engine and binds every compute job to exactly one 16-bit model index. Indices arrive on their own valid/ready stream. Job data arrives on a second valid/ready stream, and the beat that carries `in_last` closes the job. Either stream may lead. An index can be queued ahead of the data. A job whose data shows up first is stalled at the input until its index has been taken in. No beat of a job reaches the output before the job's index is known. This holds even when the system only ever uses a single model.

Up to four indices can wait in a small queue. The oldest pending index is attached to every output beat of the current job. It stays in the queue until the closing beat of that job is accepted. Jobs and indices are therefore paired strictly in arrival order. The engine itself is represented by one registered pipeline stage, which gives every accepted beat one cycle of latency. An asynchronous active-low reset empties the index queue and the output stage. This also discards any job that was partly accepted.

Top module: `mjg_job_gate`

## Requirements
- R1: While reset is applied and right after it is released, `sel_ready` is 1, `in_ready` is 0 and `out_valid` is 0.
- R2: `in_ready` is 1 only when at least one index is pending and the output stage is empty or being drained in the same cycle (`out_ready`=1). At all other times data is stalled.
- R3: The index queue holds 4 entries. `sel_ready` is 0 exactly when 4 indices are pending, and an index offered then is not taken until a job completes.
- R4: When an index is already pending, a job's first beat is accepted as soon as it is offered and the output stage is free.
- R5: When a job's data is offered before its index, nothing is accepted and nothing is output until the index handshake. The first beat is accepted in the cycle after that handshake.
- R6: Every output beat carries on `out_index` the index of its job. All beats of one job carry the same index, and that index is retired when the job's `in_last` beat is accepted.
- R7: The n-th accepted index is paired with the n-th job, counted in order of arrival, and is never reordered.
- R8: An accepted beat appears on `out_data`/`out_last` one cycle later. It is held unchanged while `out_valid`=1 and `out_ready`=0. With `out_ready` held at 1, one beat per cycle passes.
- R9: Reset applied in the middle of traffic drops every pending index and any partially accepted job. After release, data is stalled again until a new index arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| sel_valid | input | 1 | Model index offered |
| sel_ready | output | 1 | Index queue can take an index |
| sel_index | input | 16 | Model index value |
| in_valid | input | 1 | Job data beat offered |
| in_ready | output | 1 | Gate accepts the data beat |
| in_data | input | DATA_W | Job data beat |
| in_last | input | 1 | Beat closes the job |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | DATA_W | Output data beat |
| out_last | output | 1 | Output beat closes the job |
| out_index | output | 16 | Model index of the job the beat belongs to |

## Verification
The gate is driven with four arrival patterns. In the first, the index leads the data, which shows that no extra wait is added. In the second, the data leads the index, which shows the stall and the one-cycle release after the handshake. In the third, four indices are queued ahead of several one-beat jobs while a fifth index is offered, which exposes overflow, early release and any pairing out of order. In the fourth, a multi-beat job runs against a stalling downstream, which separates a correctly held output from dropped or duplicated beats. A reset in the middle of a job, with indices still pending, shows whether stale indices or half-accepted jobs survive.

// File: rtl/mjg_pkg.sv
package mjg_pkg;
  localparam int IDX_W = 16;
  typedef logic [IDX_W-1:0] model_idx_t;
endpackage

// File: rtl/mjg_index_fifo.sv
module mjg_index_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [W-1:0]  push_data,
  input  logic          pop_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == CW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push_en && !full;
  assign do_pop  = pop_en && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (do_push) wr_d = bump(wr_q);
    if (do_pop)  rd_d = bump(rd_q);
    case ({do_push, do_pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/mjg_beat_stage.sv
module mjg_beat_stage #(
  parameter int DW = 64,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_last,
  input  logic [IW-1:0] ld_index,
  input  logic          take,
  output logic          free,
  output logic          q_valid,
  output logic [DW-1:0] q_data,
  output logic          q_last,
  output logic [IW-1:0] q_index
);
  logic v_q, v_d;

  assign free = !v_q || take;

  always_comb begin
    v_d = v_q;
    if (load)      v_d = 1'b1;
    else if (take) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_data  <= ld_data;
      q_last  <= ld_last;
      q_index <= ld_index;
    end
  end

  assign q_valid = v_q;
endmodule

// File: rtl/mjg_job_gate.sv
module mjg_job_gate
  import mjg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  output logic              sel_ready,
  input  logic [IDX_W-1:0]  sel_index,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [IDX_W-1:0]  out_index
);
  model_idx_t    head_idx;
  logic [CW-1:0] pend_cnt;
  logic          q_full, q_empty, stage_free, beat_acc;

  mjg_index_fifo #(.DEPTH(DEPTH), .W(IDX_W)) u_idx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (sel_valid),
    .push_data (sel_index),
    .pop_en    (beat_acc && in_last),
    .head      (head_idx),
    .level     (pend_cnt),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign sel_ready = !q_full;
  assign in_ready  = !q_empty && stage_free;
  assign beat_acc  = in_valid && in_ready;

  mjg_beat_stage #(.DW(DATA_W), .IW(IDX_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (beat_acc),
    .ld_data  (in_data),
    .ld_last  (in_last),
    .ld_index (head_idx),
    .take     (out_ready),
    .free     (stage_free),
    .q_valid  (out_valid),
    .q_data   (out_data),
    .q_last   (out_last),
    .q_index  (out_index)
  );
endmodule

// File: rtl/mjg_job_gate_chk.sv
module mjg_job_gate_chk #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int IW     = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic [IW-1:0]     out_index,
  input logic [CW-1:0]     pend_cnt,
  input logic [IW-1:0]     head_idx
);
  a_r2_no_accept_without_index: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> pend_cnt != '0);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CW'(DEPTH));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == CW'(DEPTH) && !(in_valid && in_ready && in_last)) |=> pend_cnt == CW'(DEPTH));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_index));

  a_r6_index_held_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=> $stable(head_idx));
endmodule

bind mjg_job_gate mjg_job_gate_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IW(16)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_index (out_index),
  .pend_cnt  (pend_cnt),
  .head_idx  (head_idx)
);

// File: tb/test_mjg_job_gate.sv
module test_mjg_job_gate;
  localparam int DW = 64;
  localparam int QD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_valid = 1'b0, sel_ready;
  logic [15:0]   sel_index = '0;
  logic          in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b1, out_last;
  logic [DW-1:0] out_data;
  logic [15:0]   out_index;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mjg_job_gate #(.DATA_W(DW), .DEPTH(QD)) i_mjg_job_gate (
    .clk(clk), .rst_n(rst_n),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_index(sel_index),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_index(out_index)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: pending index queue plus one output slot.
  logic [15:0]   idxq [$];
  bit            m_ov = 1'b0;
  logic [DW-1:0] m_od;
  bit            m_ol;
  logic [15:0]   m_oi;

  always begin
    @(negedge clk);
    #3;
    if (!rst_n) begin
      idxq.delete();
      m_ov = 1'b0;
    end
    begin
      bit e_sel, e_in, f_sel, f_in, f_out;
      e_sel = idxq.size() < QD;
      e_in  = (idxq.size() > 0) && (!m_ov || out_ready);
      chk(sel_ready === e_sel, "R3", "sel_ready", DW'(sel_ready), DW'(e_sel));
      chk(in_ready === e_in, "R2", "in_ready", DW'(in_ready), DW'(e_in));
      chk(out_valid === m_ov, "R8", "out_valid", DW'(out_valid), DW'(m_ov));
      if (m_ov) begin
        chk(out_data === m_od, "R8", "out_data", out_data, m_od);
        chk(out_last === m_ol, "R8", "out_last", DW'(out_last), DW'(m_ol));
        chk(out_index === m_oi, "R6 R7", "out_index", DW'(out_index), DW'(m_oi));
      end
      if (rst_n) begin
        f_sel = sel_valid && e_sel;
        f_in  = in_valid && e_in;
        f_out = m_ov && out_ready;
        if (f_in) begin
          m_ov = 1'b1;
          m_od = in_data;
          m_ol = in_last;
          m_oi = idxq[0];
          if (in_last) void'(idxq.pop_front());
        end else if (f_out) begin
          m_ov = 1'b0;
        end
        if (f_sel) idxq.push_back(sel_index);
      end
    end
  end

  // Drivers start at a negedge and return at the negedge after the handshake.
  task automatic give_index(input logic [15:0] v);
    bit ok;
    sel_valid = 1'b1;
    sel_index = v;
    do begin
      #3 ok = sel_ready;
      @(negedge clk);
    end while (!ok);
    sel_valid = 1'b0;
  endtask

  task automatic give_beat(input logic [DW-1:0] d, input bit l);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    in_last  = l;
    do begin
      #3 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic give_job(input logic [DW-1:0] base, input int beats);
    for (int b = 0; b < beats; b++) give_beat(base + DW'(b), b == beats - 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual hung after %0d cycles expected completion", 20000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R1: idle state after reset release
    chk(sel_ready === 1'b1, "R1", "sel_ready after reset", DW'(sel_ready), 1);
    chk(in_ready === 1'b0, "R1", "in_ready after reset", DW'(in_ready), 0);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", DW'(out_valid), 0);
    @(negedge clk);

    // R4: index leads data
    give_index(16'h1111);
    #3 chk(in_ready === 1'b1, "R4", "in_ready with index pending", DW'(in_ready), 1);
    @(negedge clk);
    give_job(64'hA000, 3);
    repeat (2) @(negedge clk);

    // R5: data leads index
    fork
      give_job(64'hB000, 2);
      begin
        repeat (5) @(negedge clk);
        #3;
        chk(in_ready === 1'b0, "R5", "in_ready before index", DW'(in_ready), 0);
        chk(out_valid === 1'b0, "R5", "out_valid before index", DW'(out_valid), 0);
        @(negedge clk);
        give_index(16'h2222);
        #3 chk(in_ready === 1'b1, "R5", "in_ready cycle after index", DW'(in_ready), 1);
      end
    join
    repeat (3) @(negedge clk);

    // R3 / R7: fill the queue, offer a fifth index while jobs drain
    give_index(16'h3001);
    give_index(16'h3002);
    give_index(16'h3003);
    give_index(16'h3004);
    #3 chk(sel_ready === 1'b0, "R3", "sel_ready with 4 pending", DW'(sel_ready), 0);
    @(negedge clk);
    fork
      give_index(16'h3005);
      for (int j = 0; j < 5; j++) give_job(64'hC000 + DW'(j * 16), 1);
    join
    repeat (3) @(negedge clk);

    // R8 / R6: multi-beat job against a stalling sink
    give_index(16'h4444);
    fork
      give_job(64'hD000, 4);
      for (int k = 0; k < 14; k++) begin
        out_ready = (k % 3) != 1;
        @(negedge clk);
      end
    join
    out_ready = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset in the middle of a job with indices pending
    give_index(16'h5001);
    give_index(16'h5002);
    give_beat(64'hE000, 1'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(in_ready === 1'b0, "R9", "in_ready after flush", DW'(in_ready), 0);
    chk(sel_ready === 1'b1, "R9", "sel_ready after flush", DW'(sel_ready), 1);
    chk(out_valid === 1'b0, "R9", "out_valid after flush", DW'(out_valid), 0);
    @(negedge clk);
    give_index(16'h6006);
    give_job(64'hF000, 2);
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule